// File: doc/BRIEF.md
# Peripheral DMA Channel Controller

One channel of a DMA engine that moves 32-bit words between a memory-side port and a peripheral-side port. Software programs it through six 32-bit registers. These hold a control word, a status word, a memory pointer, a memory sequencing word, a peripheral pointer and a peripheral sequencing word. Each word moves as a read from the source side followed by a write to the sink side. The direction bit picks which side is the source. With flow control on, a word starts only when a selectable peripheral request line is high.

The channel has two modes. One-shot mode is single-buffered: it moves the programmed count and stops. Continuous mode runs a ping-pong buffer. The programmed count covers one half of the buffer. At the end of every half the channel raises end-of-count and toggles a ping-pong status bit. After the second half it reloads its working pointers from the pointer registers. Software can therefore retarget the next buffer while the channel runs. Both ports use a request/acknowledge word handshake: a transfer completes in any cycle where the request and the acknowledge are both high.

Top module: `pdma_chan`

## Requirements
- R1: After reset every register reads zero, `irq` is low and neither port requests. Register indices on `reg_addr` are 0 control, 1 status, 2 memory pointer, 3 memory sequencing, 4 peripheral pointer, 5 peripheral sequencing.
- R2: A control write with bit 31 (enable) set while enable is clear starts the channel. In the cycle after that write, status bit 31 (busy) reads 1 and status bits 15:2 hold the programmed count from control bits 15:2. A control write made while enable is already set does not restart the channel or reload the count.
- R3: With control bit 27 (once) set, the channel moves count+1 words and then clears busy. It also sets status bit 30 (end-of-count) and leaves status bits 15:2 at zero.
- R4: With control bit 28 (direction) at 1, each word is read from memory at consecutive word addresses starting at the memory pointer, then written to the peripheral. With bit 28 at 0, each word is read from the peripheral and written to consecutive memory addresses. In both cases the peripheral address stays at the peripheral pointer.
- R5: With control bit 21 (flow) at 1, a word starts only while request line `dreq[sel]` is high, where sel is control bits 20:16. With flow at 0, words are not gated.
- R6: Selector value 31 stops any new word from starting. The enable bit and busy both stay 1. Moving to a valid selector resumes the count where it stopped.
- R7: With control bit 29 (hold) at 1, no new word starts, and status bit 29 (halt) reads 1 while the channel is busy.
- R8: With once at 0 (continuous mode), each half moves count+1 words and sets end-of-count. Status bit 28 (ping-pong) toggles at every half and reads 1 after the first. Busy stays 1. Memory addresses run on across the two halves.
- R9: Pointer writes made while the channel runs take effect when the second half of the buffer ends, and not before.
- R10: Writing the status register with bit 30 set clears end-of-count. Writing it with bit 30 clear leaves end-of-count unchanged.
- R11: `irq` is high exactly when end-of-count is set, control bit 30 (interrupt enable) is set and memory sequencing bit 31 (interrupt enable) is set.
- R12: A control write with enable clear drops busy in the next cycle, and no further word is moved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| dreq | input | NUM_REQ | Peripheral request lines |
| m_req | output | 1 | Memory-side request |
| m_we | output | 1 | Memory-side write (1) or read (0) |
| m_addr | output | AW | Memory word address |
| m_wdata | output | 32 | Memory write data |
| m_rdata | input | 32 | Memory read data |
| m_ack | input | 1 | Memory-side acknowledge |
| p_req | output | 1 | Peripheral-side request |
| p_we | output | 1 | Peripheral-side write (1) or read (0) |
| p_addr | output | AW | Peripheral address |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data |
| p_ack | input | 1 | Peripheral-side acknowledge |
| irq | output | 1 | End-of-count interrupt |

## Verification
One-shot transfers are swept over every count from one to four words in the memory-to-peripheral direction, and from one to three words in the reverse direction. Word-for-word comparison of data and addresses separates an off-by-one in the count from a wrong address step or a swapped source. Stall patterns follow: a low request line, the reserved selector, and hold. Each is released later, and the total word count shows whether the stall froze the count or restarted it. A continuous run with a pointer rewrite in its second half shows whether the ping-pong bit toggles and whether the new pointer lands exactly at the wrap.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
   localparam int DW        = 32;
   localparam int SEL_W     = 5;
   localparam int SEL_OFF   = 31;
   localparam int CNT_LSB   = 2;
   localparam int CNT_FIELD = 14;
   // control bits
   localparam int B_EN   = 31;
   localparam int B_IE   = 30;
   localparam int B_HOLD = 29;
   localparam int B_DIR  = 28;
   localparam int B_ONCE = 27;
   localparam int B_FLOW = 21;
   localparam int B_SEL  = 16;
   // status bits
   localparam int B_BUSY = 31;
   localparam int B_EOC  = 30;
   localparam int B_HALT = 29;
   localparam int B_PP   = 28;
   // memory sequencing interrupt enable
   localparam int B_SEQ_IE = 31;
   localparam logic [31:0] CTRL_MASK = 32'hF83F_FFFC;

   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_STAT = 3'd1,
      REG_MPTR = 3'd2,
      REG_MSEQ = 3'd3,
      REG_PPTR = 3'd4,
      REG_PSEQ = 3'd5
   } reg_idx_e;

   typedef enum logic [1:0] {
      MV_IDLE = 2'd0,
      MV_RD   = 2'd1,
      MV_WR   = 2'd2
   } mv_state_e;
endpackage

// File: rtl/pdma_reqsel.sv
module pdma_reqsel import pdma_pkg::*; #(
   parameter int NUM_REQ = 8
) (
   input  logic [NUM_REQ-1:0] dreq,
   input  logic [SEL_W-1:0]   sel,
   input  logic               flow,
   output logic               ok
);
   localparam int LINES = 1 << SEL_W;
   logic [LINES-1:0] lines;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      if (i < NUM_REQ && i != SEL_OFF) begin : g_real
         assign lines[i] = dreq[i];
      end else begin : g_tie
         assign lines[i] = 1'b0;
      end
   end

   always_comb begin
      if (sel == SEL_W'(SEL_OFF)) ok = 1'b0;
      else if (flow)              ok = lines[sel];
      else                        ok = 1'b1;
   end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq import pdma_pkg::*; #(
   parameter int AW    = 32,
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             once,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic [AW-1:0]    mptr,
   input  logic [AW-1:0]    pptr,
   input  logic             word_done,
   input  logic             clr_eoc,
   output logic             busy,
   output logic [CNT_W-1:0] rem,
   output logic             pp,
   output logic             eoc,
   output logic             eoc_set,
   output logic [AW-1:0]    maddr,
   output logic [AW-1:0]    paddr
);
   logic last;
   assign last    = (rem == '0);
   assign eoc_set = word_done && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         rem   <= '0;
         pp    <= 1'b0;
         maddr <= '0;
         paddr <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         rem   <= load_cnt;
         pp    <= 1'b0;
         maddr <= mptr;
         paddr <= pptr;
      end else if (stop) begin
         busy  <= 1'b0;
      end else if (word_done) begin
         if (!last) begin
            rem   <= rem - 1'b1;
            maddr <= maddr + AW'(4);
         end else if (once) begin
            busy  <= 1'b0;
            maddr <= maddr + AW'(4);
         end else begin
            rem <= load_cnt;
            pp  <= ~pp;
            if (pp) begin
               maddr <= mptr;
               paddr <= pptr;
            end else begin
               maddr <= maddr + AW'(4);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       eoc <= 1'b0;
      else if (eoc_set) eoc <= 1'b1;
      else if (clr_eoc) eoc <= 1'b0;
   end
endmodule

// File: rtl/pdma_mover.sv
module pdma_mover import pdma_pkg::*; #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          busy,
   input  logic          dir,
   input  logic [AW-1:0] maddr,
   input  logic [AW-1:0] paddr,
   output logic          m_req,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [DW-1:0] m_wdata,
   input  logic [DW-1:0] m_rdata,
   input  logic          m_ack,
   output logic          p_req,
   output logic          p_we,
   output logic [AW-1:0] p_addr,
   output logic [DW-1:0] p_wdata,
   input  logic [DW-1:0] p_rdata,
   input  logic          p_ack,
   output logic          word_done
);
   mv_state_e     st;
   logic [DW-1:0] data_q;
   logic          src_ack, dst_ack;
   logic [DW-1:0] src_data;

   assign src_ack   = dir ? m_ack   : p_ack;
   assign dst_ack   = dir ? p_ack   : m_ack;
   assign src_data  = dir ? m_rdata : p_rdata;
   assign word_done = busy && (st == MV_WR) && dst_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= MV_IDLE;
         data_q <= '0;
      end else begin
         unique case (st)
            MV_IDLE: if (go) st <= MV_RD;
            MV_RD: begin
               if (!busy) st <= MV_IDLE;
               else if (src_ack) begin
                  data_q <= src_data;
                  st     <= MV_WR;
               end
            end
            MV_WR: if (!busy || dst_ack) st <= MV_IDLE;
            default: st <= MV_IDLE;
         endcase
      end
   end

   always_comb begin
      m_req = busy && ((st == MV_RD && dir) || (st == MV_WR && !dir));
      p_req = busy && ((st == MV_RD && !dir) || (st == MV_WR && dir));
   end
   assign m_we    = (st == MV_WR);
   assign p_we    = (st == MV_WR);
   assign m_addr  = maddr;
   assign p_addr  = paddr;
   assign m_wdata = data_q;
   assign p_wdata = data_q;
endmodule

// File: rtl/pdma_chan.sv
module pdma_chan import pdma_pkg::*; #(
   parameter int AW      = 32,
   parameter int NUM_REQ = 8,
   parameter int CNT_W   = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [2:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [NUM_REQ-1:0] dreq,
   output logic               m_req,
   output logic               m_we,
   output logic [AW-1:0]      m_addr,
   output logic [31:0]        m_wdata,
   input  logic [31:0]        m_rdata,
   input  logic               m_ack,
   output logic               p_req,
   output logic               p_we,
   output logic [AW-1:0]      p_addr,
   output logic [31:0]        p_wdata,
   input  logic [31:0]        p_rdata,
   input  logic               p_ack,
   output logic               irq
);
   if (AW < 3 || AW > 32) begin : g_bad_aw
      $error("pdma_chan: AW must lie in 3..32");
   end
   if (NUM_REQ < 1 || NUM_REQ > SEL_OFF) begin : g_bad_req
      $error("pdma_chan: NUM_REQ must lie in 1..31");
   end
   if (CNT_W < 1 || CNT_W > CNT_FIELD) begin : g_bad_cnt
      $error("pdma_chan: CNT_W must lie in 1..14");
   end

   logic [31:0]      ctrl_q, mseq_q, pseq_q;
   logic [AW-1:0]    mptr_q, pptr_q;
   logic             wr_ctrl, wr_stat, start, stop, clr_eoc;
   logic             busy, pp, eoc, eoc_set, word_done, gate_ok, go;
   logic [CNT_W-1:0] rem, load_cnt;
   logic [AW-1:0]    maddr, paddr;

   assign wr_ctrl  = reg_we && (reg_addr == REG_CTRL);
   assign wr_stat  = reg_we && (reg_addr == REG_STAT);
   assign start    = wr_ctrl && reg_wdata[B_EN] && !ctrl_q[B_EN];
   assign stop     = wr_ctrl && !reg_wdata[B_EN];
   assign clr_eoc  = wr_stat && reg_wdata[B_EOC];
   assign load_cnt = start ? reg_wdata[CNT_LSB +: CNT_W] : ctrl_q[CNT_LSB +: CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mseq_q <= '0;
         pseq_q <= '0;
         mptr_q <= '0;
         pptr_q <= '0;
      end else if (reg_we) begin
         unique case (reg_addr)
            REG_CTRL: ctrl_q <= reg_wdata & CTRL_MASK;
            REG_MPTR: mptr_q <= {reg_wdata[AW-1:2], 2'b00};
            REG_MSEQ: mseq_q <= reg_wdata;
            REG_PPTR: pptr_q <= {reg_wdata[AW-1:2], 2'b00};
            REG_PSEQ: pseq_q <= reg_wdata;
            default: ;
         endcase
      end
   end

   pdma_reqsel #(.NUM_REQ(NUM_REQ)) u_reqsel (
      .dreq (dreq),
      .sel  (ctrl_q[B_SEL +: SEL_W]),
      .flow (ctrl_q[B_FLOW]),
      .ok   (gate_ok)
   );

   assign go = busy && gate_ok && !ctrl_q[B_HOLD];

   pdma_seq #(.AW(AW), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .once      (ctrl_q[B_ONCE]),
      .load_cnt  (load_cnt),
      .mptr      (mptr_q),
      .pptr      (pptr_q),
      .word_done (word_done),
      .clr_eoc   (clr_eoc),
      .busy      (busy),
      .rem       (rem),
      .pp        (pp),
      .eoc       (eoc),
      .eoc_set   (eoc_set),
      .maddr     (maddr),
      .paddr     (paddr)
   );

   pdma_mover #(.AW(AW)) u_mover (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .busy      (busy),
      .dir       (ctrl_q[B_DIR]),
      .maddr     (maddr),
      .paddr     (paddr),
      .m_req     (m_req),
      .m_we      (m_we),
      .m_addr    (m_addr),
      .m_wdata   (m_wdata),
      .m_rdata   (m_rdata),
      .m_ack     (m_ack),
      .p_req     (p_req),
      .p_we      (p_we),
      .p_addr    (p_addr),
      .p_wdata   (p_wdata),
      .p_rdata   (p_rdata),
      .p_ack     (p_ack),
      .word_done (word_done)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         REG_CTRL: reg_rdata = ctrl_q;
         REG_STAT: begin
            reg_rdata[B_BUSY]             = busy;
            reg_rdata[B_EOC]              = eoc;
            reg_rdata[B_HALT]             = busy && ctrl_q[B_HOLD];
            reg_rdata[B_PP]               = pp;
            reg_rdata[CNT_LSB +: CNT_W]   = rem;
         end
         REG_MPTR: reg_rdata = 32'(mptr_q);
         REG_MSEQ: reg_rdata = mseq_q;
         REG_PPTR: reg_rdata = 32'(pptr_q);
         REG_PSEQ: reg_rdata = pseq_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = eoc && ctrl_q[B_IE] && mseq_q[B_SEQ_IE];
endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       stop,
   input logic       clr_eoc,
   input logic       eoc_set,
   input logic       busy,
   input logic       eoc,
   input logic       irq,
   input logic       ie_ctrl,
   input logic       ie_seq,
   input logic [4:0] sel,
   input logic       hold,
   input logic       m_req,
   input logic       p_req
);
   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R12
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !busy);

   // R10
   eoc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_eoc && !eoc_set) |=> (!eoc && !irq));

   // R11
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_set && ie_ctrl && ie_seq && !start && !stop) |=> irq);

   // R6
   word_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_req || p_req) |-> ($past(sel) != 5'd31 && !$past(hold)));

   // R4
   side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({m_req, p_req}));
endmodule

bind pdma_chan pdma_chan_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .stop    (stop),
   .clr_eoc (clr_eoc),
   .eoc_set (eoc_set),
   .busy    (busy),
   .eoc     (eoc),
   .irq     (irq),
   .ie_ctrl (ctrl_q[30]),
   .ie_seq  (mseq_q[31]),
   .sel     (ctrl_q[20:16]),
   .hold    (ctrl_q[29]),
   .m_req   (m_req),
   .p_req   (p_req)
);

// File: tb/pdma_chan_tb.sv
module pdma_chan_tb;
   localparam int AW = 32;
   localparam int NR = 8;
   localparam logic [31:0] EN = 32'h8000_0000, IE = 32'h4000_0000, HOLD = 32'h2000_0000;
   localparam logic [31:0] DIR = 32'h1000_0000, ONCE = 32'h0800_0000, FLOW = 32'h0020_0000;
   localparam logic [31:0] SEQ_IE = 32'h8000_0000 | (32'd2 << 28) | (32'd4 << 24);

   logic clk = 0, rst_n = 0;
   logic reg_we = 0;
   logic [2:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic [NR-1:0] dreq = 0;
   logic m_req, m_we, m_ack, p_req, p_we, p_ack, irq;
   logic [AW-1:0] m_addr, p_addr;
   logic [31:0] m_wdata, m_rdata, p_wdata, p_rdata;

   int ntests = 0, nfail = 0;
   int pn = 0, mn = 0, pcnt = 0, pa_bad = 0;
   logic [31:0] exp_pa = 0;
   logic [31:0] plog [256];
   logic [31:0] mlog_a [256];
   logic [31:0] mlog_d [256];

   always #5 clk = ~clk;

   assign m_ack   = m_req;
   assign p_ack   = p_req;
   assign m_rdata = 32'hC0DE_0000 ^ m_addr;
   assign p_rdata = 32'h5A00_0000 ^ pcnt;

   always @(posedge clk) if (p_req && !p_we && p_ack) pcnt <= pcnt + 1;

   always @(negedge clk) begin
      if (p_req && p_we && p_ack) begin plog[pn % 256] = p_wdata; pn = pn + 1; end
      if (m_req && m_we && m_ack) begin
         mlog_a[mn % 256] = m_addr; mlog_d[mn % 256] = m_wdata; mn = mn + 1;
      end
      if (p_req && p_addr != exp_pa) pa_bad = pa_bad + 1;
   end

   pdma_chan #(.AW(AW), .NUM_REQ(NR), .CNT_W(14)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_rdata(m_rdata), .m_ack(m_ack), .p_req(p_req), .p_we(p_we),
      .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata), .p_ack(p_ack),
      .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      ntests++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] s;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk); rd(3'd1, s);
         if (!s[31]) return;
      end
      chk({tag, " timeout"}, 32'd1, 32'd0);
   endtask

   task automatic wait_irq(input string tag);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (irq) return;
      end
      chk({tag, " irq timeout"}, 32'd1, 32'd0);
   endtask

   task automatic setup(input logic [31:0] mp, input logic [31:0] pp_, input logic [31:0] mseq);
      wr(3'd0, 32'h0);
      wr(3'd1, 32'h4000_0000);
      wr(3'd2, mp); wr(3'd4, pp_); wr(3'd3, mseq);
      exp_pa = pp_;
   endtask

   initial begin
      #(200000 * 10);
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

   initial begin
      logic [31:0] s;
      int p0, m0, c0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), s); chk($sformatf("R1 reg %0d", a), s, 32'h0);
      end
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 req", {30'b0, m_req, p_req}, 32'h0);

      // R3 R4 one-shot memory to peripheral, sweep of counts
      for (int n = 1; n <= 4; n++) begin
         setup(32'h100 + 32'(n) * 32'h40, 32'h80, SEQ_IE);
         p0 = pn; pa_bad = 0;
         wr(3'd0, EN | IE | DIR | ONCE | (32'(n - 1) << 2));
         wait_idle("R3 m2p");
         @(negedge clk);
         chk($sformatf("R3 words n=%0d", n), 32'(pn - p0), 32'(n));
         for (int k = 0; k < n; k++)
            chk($sformatf("R4 data n=%0d k=%0d", n, k), plog[(p0 + k) % 256],
                32'hC0DE_0000 ^ (32'h100 + 32'(n) * 32'h40 + 32'(4 * k)));
         rd(3'd1, s);
         chk("R3 eoc", {31'b0, s[30]}, 32'h1);
         chk("R3 remaining", {18'b0, s[15:2]}, 32'h0);
         chk("R11 irq on", {31'b0, irq}, 32'h1);
         chk("R4 paddr fixed", 32'(pa_bad), 32'h0);
      end

      // R4 peripheral to memory
      for (int n = 1; n <= 3; n++) begin
         setup(32'h400, 32'h90, SEQ_IE);
         m0 = mn; c0 = pcnt; pa_bad = 0;
         wr(3'd0, EN | IE | ONCE | (32'(n - 1) << 2));
         wait_idle("R4 p2m");
         @(negedge clk);
         chk($sformatf("R4 p2m words n=%0d", n), 32'(mn - m0), 32'(n));
         for (int k = 0; k < n; k++) begin
            chk("R4 p2m addr", mlog_a[(m0 + k) % 256], 32'h400 + 32'(4 * k));
            chk("R4 p2m data", mlog_d[(m0 + k) % 256], 32'h5A00_0000 ^ 32'(c0 + k));
         end
         chk("R4 p2m paddr", 32'(pa_bad), 32'h0);
      end

      // R10 write-0 keeps, write-1 clears
      wr(3'd1, 32'h0);
      rd(3'd1, s); chk("R10 write0 keeps eoc", {31'b0, s[30]}, 32'h1);
      wr(3'd1, 32'h4000_0000);
      rd(3'd1, s); chk("R10 write1 clears eoc", {31'b0, s[30]}, 32'h0);
      chk("R10 irq low", {31'b0, irq}, 32'h0);

      // R11 interrupt gating
      setup(32'h100, 32'h80, SEQ_IE);
      wr(3'd0, EN | DIR | ONCE);
      wait_idle("R11 a");
      rd(3'd1, s); chk("R11 eoc set", {31'b0, s[30]}, 32'h1);
      chk("R11 ctrl ie off", {31'b0, irq}, 32'h0);
      setup(32'h100, 32'h80, SEQ_IE & 32'h7FFF_FFFF);
      wr(3'd0, EN | IE | DIR | ONCE);
      wait_idle("R11 b");
      chk("R11 seq ie off", {31'b0, irq}, 32'h0);
      wr(3'd3, SEQ_IE);
      chk("R11 both on", {31'b0, irq}, 32'h1);

      // R5 flow control
      setup(32'h100, 32'h80, SEQ_IE);
      p0 = pn; dreq = '0;
      wr(3'd0, EN | DIR | ONCE | FLOW | (32'd2 << 16) | (32'd1 << 2));
      repeat (20) @(negedge clk);
      chk("R5 stalled words", 32'(pn - p0), 32'h0);
      rd(3'd1, s); chk("R5 stalled count", {18'b0, s[15:2]}, 32'h1);
      dreq[1] = 1'b1;
      repeat (20) @(negedge clk);
      chk("R5 other line", 32'(pn - p0), 32'h0);
      dreq[2] = 1'b1;
      wait_idle("R5");
      @(negedge clk);
      chk("R5 released words", 32'(pn - p0), 32'h2);
      dreq = '0;

      // R6 R2 invalid selector
      setup(32'h100, 32'h80, SEQ_IE);
      p0 = pn;
      wr(3'd0, EN | DIR | ONCE | (32'd31 << 16) | (32'd3 << 2));
      rd(3'd1, s);
      chk("R2 busy next cycle", {31'b0, s[31]}, 32'h1);
      chk("R2 count loaded", {18'b0, s[15:2]}, 32'h3);
      repeat (20) @(negedge clk);
      chk("R6 no words", 32'(pn - p0), 32'h0);
      rd(3'd1, s); chk("R6 still busy", {31'b0, s[31]}, 32'h1);
      rd(3'd0, s); chk("R6 enable kept", {31'b0, s[31]}, 32'h1);
      wr(3'd0, EN | DIR | ONCE | (32'd3 << 2));
      wait_idle("R6");
      @(negedge clk);
      chk("R2 no restart words", 32'(pn - p0), 32'h4);

      // R7 hold
      setup(32'h100, 32'h80, SEQ_IE);
      p0 = pn;
      wr(3'd0, EN | HOLD | DIR | ONCE | (32'd1 << 2));
      repeat (20) @(negedge clk);
      chk("R7 no words", 32'(pn - p0), 32'h0);
      rd(3'd1, s); chk("R7 halt flag", {31'b0, s[29]}, 32'h1);
      wr(3'd0, EN | DIR | ONCE | (32'd1 << 2));
      wait_idle("R7");
      @(negedge clk);
      chk("R7 released words", 32'(pn - p0), 32'h2);
      rd(3'd1, s); chk("R7 halt clear", {31'b0, s[29]}, 32'h0);

      // R8 R9 continuous with pointer retarget, R12 stop
      setup(32'h100, 32'h80, SEQ_IE);
      p0 = pn;
      wr(3'd0, EN | IE | DIR | (32'd1 << 2));
      wait_irq("R8 first half");
      wr(3'd2, 32'h200);
      rd(3'd1, s);
      chk("R8 pingpong after first half", {31'b0, s[28]}, 32'h1);
      chk("R8 busy in continuous", {31'b0, s[31]}, 32'h1);
      wr(3'd1, 32'h4000_0000);
      wait_irq("R8 second half");
      rd(3'd1, s);
      chk("R8 pingpong after second half", {31'b0, s[28]}, 32'h0);
      for (int i = 0; i < 400 && (pn - p0) < 6; i++) @(negedge clk);
      wr(3'd0, 32'h0);
      rd(3'd1, s); chk("R12 busy cleared", {31'b0, s[31]}, 32'h0);
      c0 = pn;
      repeat (20) @(negedge clk);
      chk("R12 no further words", 32'(pn - c0), 32'h0);
      for (int k = 0; k < 4; k++)
         chk($sformatf("R8 buffer word %0d", k), plog[(p0 + k) % 256],
             32'hC0DE_0000 ^ (32'h100 + 32'(4 * k)));
      for (int k = 0; k < 2; k++)
         chk($sformatf("R9 retarget word %0d", k), plog[(p0 + 4 + k) % 256],
             32'hC0DE_0000 ^ (32'h200 + 32'(4 * k)));

      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end
endmodule